// File: doc/BRIEF.md
# DVFS Load-Level Register Controller

This block is the register file of a power manager that runs the CPU at one of four load levels. Each level holds four settings: a clock-source select, a clock-generator index, a clock divider and a supply-voltage select. Two levels share each 32-bit level register, one in each 16-bit half. A load register names the active level, with level 0 as the highest-performance level. A dynamic-mode register holds a master scaling enable and one enable for each kind of setting.

The block decodes the active level onto output ports: the divider, the source select, the generator index and the VDD select. It also gives a one-cycle strobe whenever those decoded outputs change. Software programs the block through a simple synchronous register bus. Reads return data one cycle after the request.

While the master enable is set, the level registers and the load register refuse writes. To change them, software first clears the master enable, then rewrites the level and load registers, and writes the dynamic-mode register last.

Top module: `dvfs_lvl_ctrl`

## Requirements
- R1: After reset every register reads 0, the outputs are divider 1, source 0, generator 0 and VDD 0, and chg_o is low.
- R2: The register map is: level-pair register A at 0x18, level-pair register B at 0x1C, dynamic-mode register at 0x24 and load register at 0x30. A read returns the stored value on bus_rdata_o one clock after the request. The load register stores only bits [1:0], and its other bits read 0.
- R3: Level 0 sits in bits [31:16] of 0x18 and level 1 in bits [15:0] of 0x18. Level 2 sits in bits [31:16] of 0x1C and level 3 in bits [15:0] of 0x1C. Within each 16-bit half, the divider is bits [15:13], the source select is bit 11, the generator index is bits [10:9] and the VDD select is bits [7:6].
- R4: The outputs show the settings of the level named by the load register. They change on the second clock edge after the write edge that changes a setting, an enable or the load value.
- R5: Each output is driven from the active level only when dynamic-mode bit 31 (master enable) is set and that output's own enable bit is set: bit 26 for source, bit 28 for generator, bit 29 for divider and bit 30 for VDD. Otherwise the output holds its default: divider 1, source 0, generator 0, VDD 0.
- R6: While stored dynamic-mode bit 31 is 1, writes to 0x18, 0x1C and 0x30 are ignored. The dynamic-mode register itself stays writable.
- R7: Every register reads back its stored value whether or not the master enable is set.
- R8: An offset outside the map reads 0, and a write to it changes no register.
- R9: A divider field of 0 appears on clk_div_o as 1 when the divider is enabled.
- R10: chg_o is high for exactly the cycles in which the decoded outputs differ from their values in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid one cycle after a read request |
| clk_div_o | output | 3 | Active clock divider |
| src_sel_o | output | 1 | Active clock-source select (1 = generator) |
| gen_sel_o | output | 2 | Active clock-generator index |
| vdd_sel_o | output | 2 | Active supply-voltage select |
| chg_o | output | 1 | One-cycle pulse when the decoded settings change |

## Verification
A corrupted level field or load pointer shows on the setting outputs two edges after the write that exposes it, and an explicit read of the level registers exposes it one cycle after the read. A lock that leaks shows as a changed readback or as an output that moves during a locked write. A faulty enable gate shows up as soon as the master bit or a per-setting bit toggles. A broken change detector shows as a strobe that is missing on the edge where the outputs move, or that lasts longer than one cycle.

// File: rtl/dvfs_lvl_pkg.sv
package dvfs_lvl_pkg;
  localparam int DATA_W  = 32;
  localparam int HALF_W  = 16;
  localparam int OFF_LVL = 'h18;  // first level-pair register, next at +4
  localparam int OFF_DYN = 'h24;
  localparam int OFF_LD  = 'h30;

  localparam int DIV_LSB = 13;
  localparam int DIV_W   = 3;
  localparam int SRC_BIT = 11;
  localparam int GEN_LSB = 9;
  localparam int GEN_W   = 2;
  localparam int VDD_LSB = 6;
  localparam int VDD_W   = 2;

  localparam int EN_SRC = 26;
  localparam int EN_GEN = 28;
  localparam int EN_DIV = 29;
  localparam int EN_VDD = 30;
  localparam int EN_ALL = 31;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             src;
    logic [GEN_W-1:0] gen;
    logic [VDD_W-1:0] vdd;
  } lvl_cfg_t;

  localparam lvl_cfg_t CFG_DFLT = '{div: 3'd1, src: 1'b0, gen: 2'd0, vdd: 2'd0};
endpackage

// File: rtl/dvfs_lvl_regs.sv
module dvfs_lvl_regs
  import dvfs_lvl_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_LVL = 4,
  localparam int NUM_REG = NUM_LVL / 2,
  localparam int LD_W    = $clog2(NUM_LVL)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_i,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [DATA_W-1:0]               rdata_o,
  output logic [NUM_REG-1:0][DATA_W-1:0]  lvl_q_o,
  output logic [DATA_W-1:0]               dyn_q_o,
  output logic [LD_W-1:0]                 ld_q_o
);
  logic locked;
  logic wr;
  logic [DATA_W-1:0] rsel;

  assign locked = dyn_q_o[EN_ALL];
  assign wr     = req_i & we_i;

  for (genvar p = 0; p < NUM_REG; p++) begin : g_pair
    logic hit;
    assign hit = wr && !locked && (addr_i == ADDR_W'(OFF_LVL + 4 * p));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  lvl_q_o[p] <= '0;
      else if (hit) lvl_q_o[p] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dyn_q_o <= '0;
      ld_q_o  <= '0;
    end else begin
      if (wr && addr_i == ADDR_W'(OFF_DYN)) dyn_q_o <= wdata_i;
      if (wr && !locked && addr_i == ADDR_W'(OFF_LD)) ld_q_o <= wdata_i[LD_W-1:0];
    end
  end

  always_comb begin
    rsel = '0;
    for (int p = 0; p < NUM_REG; p++)
      if (addr_i == ADDR_W'(OFF_LVL + 4 * p)) rsel = lvl_q_o[p];
    if (addr_i == ADDR_W'(OFF_DYN)) rsel = dyn_q_o;
    if (addr_i == ADDR_W'(OFF_LD))  rsel = {{(DATA_W-LD_W){1'b0}}, ld_q_o};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rdata_o <= '0;
    else if (req_i && !we_i) rdata_o <= rsel;
  end
endmodule

// File: rtl/dvfs_lvl_decode.sv
module dvfs_lvl_decode
  import dvfs_lvl_pkg::*;
#(
  parameter int NUM_LVL = 4,
  localparam int NUM_REG = NUM_LVL / 2,
  localparam int LD_W    = $clog2(NUM_LVL)
) (
  input  logic [NUM_REG-1:0][DATA_W-1:0] lvl_q_i,
  input  logic [DATA_W-1:0]              dyn_q_i,
  input  logic [LD_W-1:0]                ld_q_i,
  output lvl_cfg_t                       cfg_o
);
  lvl_cfg_t cfg_arr [NUM_LVL];
  lvl_cfg_t act;
  logic     master;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    localparam int SH = (l % 2 == 0) ? HALF_W : 0;  // even levels in upper half
    logic [HALF_W-1:0] h;
    assign h = lvl_q_i[l/2][SH +: HALF_W];
    assign cfg_arr[l] = '{div: h[DIV_LSB +: DIV_W], src: h[SRC_BIT],
                          gen: h[GEN_LSB +: GEN_W], vdd: h[VDD_LSB +: VDD_W]};
  end

  assign act    = cfg_arr[ld_q_i];
  assign master = dyn_q_i[EN_ALL];

  always_comb begin
    cfg_o = CFG_DFLT;
    if (master && dyn_q_i[EN_DIV]) cfg_o.div = (act.div == '0) ? DIV_W'(1) : act.div;
    if (master && dyn_q_i[EN_SRC]) cfg_o.src = act.src;
    if (master && dyn_q_i[EN_GEN]) cfg_o.gen = act.gen;
    if (master && dyn_q_i[EN_VDD]) cfg_o.vdd = act.vdd;
  end
endmodule

// File: rtl/dvfs_lvl_strobe.sv
module dvfs_lvl_strobe
  import dvfs_lvl_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  lvl_cfg_t cfg_i,
  output lvl_cfg_t cfg_q_o,
  output logic     chg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q_o <= CFG_DFLT;
      chg_o   <= 1'b0;
    end else begin
      cfg_q_o <= cfg_i;
      chg_o   <= (cfg_i != cfg_q_o);
    end
  end
endmodule

// File: rtl/dvfs_lvl_ctrl.sv
module dvfs_lvl_ctrl
  import dvfs_lvl_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_LVL = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [2:0]        clk_div_o,
  output logic              src_sel_o,
  output logic [1:0]        gen_sel_o,
  output logic [1:0]        vdd_sel_o,
  output logic              chg_o
);
  localparam int NUM_REG = NUM_LVL / 2;
  localparam int LD_W    = $clog2(NUM_LVL);

  logic [NUM_REG-1:0][DATA_W-1:0] lvl_q;
  logic [DATA_W-1:0]              dyn_q;
  logic [LD_W-1:0]                ld_q;
  lvl_cfg_t                       cfg_nxt;
  lvl_cfg_t                       cfg_q;

  dvfs_lvl_regs #(.ADDR_W(ADDR_W), .NUM_LVL(NUM_LVL)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (bus_req_i),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .lvl_q_o (lvl_q),
    .dyn_q_o (dyn_q),
    .ld_q_o  (ld_q)
  );

  dvfs_lvl_decode #(.NUM_LVL(NUM_LVL)) u_dec (
    .lvl_q_i (lvl_q),
    .dyn_q_i (dyn_q),
    .ld_q_i  (ld_q),
    .cfg_o   (cfg_nxt)
  );

  dvfs_lvl_strobe u_stb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_i   (cfg_nxt),
    .cfg_q_o (cfg_q),
    .chg_o   (chg_o)
  );

  assign clk_div_o = cfg_q.div;
  assign src_sel_o = cfg_q.src;
  assign gen_sel_o = cfg_q.gen;
  assign vdd_sel_o = cfg_q.vdd;
endmodule

// File: rtl/dvfs_lvl_chk.sv
module dvfs_lvl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_rdata_o,
  input logic [2:0]        clk_div_o,
  input logic              src_sel_o,
  input logic [1:0]        gen_sel_o,
  input logic [1:0]        vdd_sel_o,
  input logic              chg_o,
  input logic [63:0]       lvl_flat,
  input logic [31:0]       dyn_q
);
  logic [7:0] outs;
  logic       lvl_addr, ld_addr, mapped;
  assign outs     = {clk_div_o, src_sel_o, gen_sel_o, vdd_sel_o};
  assign lvl_addr = (bus_addr_i == ADDR_W'('h18)) || (bus_addr_i == ADDR_W'('h1C));
  assign ld_addr  = (bus_addr_i == ADDR_W'('h30));
  assign mapped   = lvl_addr || ld_addr || (bus_addr_i == ADDR_W'('h24));

  p_dflt_when_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dyn_q[31] |=> (clk_div_o == 3'd1 && !src_sel_o && gen_sel_o == 2'd0 && vdd_sel_o == 2'd0));

  p_div_nonzero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_div_o != 3'd0);

  p_chg_on_diff_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> outs != $past(outs));

  p_quiet_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chg_o |-> $stable(outs));

  p_lock_lvl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && dyn_q[31] && lvl_addr) |=> $stable(lvl_flat));

  p_unmapped_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && !mapped) |=> bus_rdata_o == 32'd0);
endmodule

bind dvfs_lvl_ctrl dvfs_lvl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .clk_div_o   (clk_div_o),
  .src_sel_o   (src_sel_o),
  .gen_sel_o   (gen_sel_o),
  .vdd_sel_o   (vdd_sel_o),
  .chg_o       (chg_o),
  .lvl_flat    (lvl_q),
  .dyn_q       (dyn_q)
);

// File: tb/sim_dvfs_lvl_ctrl.sv
`timescale 1ns/1ps
module sim_dvfs_lvl_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  div;
  logic        src;
  logic [1:0]  gen, vdd;
  logic        chg;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [31:0] ALL_EN = 32'hF400_0000;

  always #5 clk = ~clk;

  dvfs_lvl_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .clk_div_o(div), .src_sel_o(src), .gen_sel_o(gen), .vdd_sel_o(vdd),
    .chg_o(chg)
  );

  function automatic logic [15:0] half(int d, int s, int g, int v);
    return 16'((d << 13) | (s << 11) | (g << 9) | (v << 6));
  endfunction

  task automatic check(string req_id, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req_id, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic chk_out(string req_id, int d, int s, int g, int v);
    check(req_id, {24'd0, div, src, gen, vdd}, {24'd0, 3'(d), 1'(s), 2'(g), 2'(v)});
  endtask

  task automatic select(int lvl, logic [31:0] dyn);
    bus_wr(8'h24, 32'd0);
    bus_wr(8'h30, 32'(lvl));
    bus_wr(8'h24, dyn);
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk_out("R1", 1, 0, 0, 0);
    check("R1 chg", {31'd0, chg}, 32'd0);
    bus_rd(8'h18, d); check("R1 lvlA", d, 0);
    bus_rd(8'h1C, d); check("R1 lvlB", d, 0);
    bus_rd(8'h24, d); check("R1 dyn", d, 0);
    bus_rd(8'h30, d); check("R1 load", d, 0);
  endtask

  task automatic t_program();
    logic [31:0] d;
    bus_wr(8'h18, {half(1,1,2,0), half(2,1,2,1)});
    bus_wr(8'h1C, {half(4,1,0,2), half(0,1,1,3)});
    bus_rd(8'h18, d); check("R2 lvlA", d, {half(1,1,2,0), half(2,1,2,1)});
    bus_rd(8'h1C, d); check("R2 lvlB", d, {half(4,1,0,2), half(0,1,1,3)});
    bus_wr(8'h30, 32'hFFFF_FFFE);
    bus_rd(8'h30, d); check("R2 load bits", d, 32'd2);
    settle();
    chk_out("R5 master off", 1, 0, 0, 0);
  endtask

  task automatic t_levels();
    bus_wr(8'h30, 32'd0);
    bus_wr(8'h24, ALL_EN);
    settle();
    chk_out("R3 R4 level0", 1, 1, 2, 0);
    check("R10 pulse", {31'd0, chg}, 32'd1);
    settle();
    check("R10 one cycle", {31'd0, chg}, 32'd0);
    select(1, ALL_EN); chk_out("R3 level1", 2, 1, 2, 1);
    select(2, ALL_EN); chk_out("R3 level2", 4, 1, 0, 2);
    select(3, ALL_EN); chk_out("R9 level3 div0", 1, 1, 1, 3);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    select(0, ALL_EN);
    settle();
    bus_wr(8'h30, 32'd1);
    bus_wr(8'h18, 32'd0);
    settle();
    chk_out("R6 outputs held", 1, 1, 2, 0);
    check("R6 no strobe", {31'd0, chg}, 32'd0);
    bus_rd(8'h30, d); check("R6 R7 load kept", d, 32'd0);
    bus_rd(8'h18, d); check("R6 R7 lvlA kept", d, {half(1,1,2,0), half(2,1,2,1)});
    bus_rd(8'h24, d); check("R7 dyn read locked", d, ALL_EN);
    bus_wr(8'h24, 32'd0);
    settle();
    chk_out("R6 dyn writable", 1, 0, 0, 0);
  endtask

  task automatic t_partial();
    select(2, 32'hA000_0000);
    chk_out("R5 div only", 4, 0, 0, 0);
    select(1, 32'h5400_0000);
    chk_out("R5 no master", 1, 0, 0, 0);
    select(1, 32'h9400_0000);
    chk_out("R5 src gen", 1, 1, 2, 0);
    select(2, 32'hC000_0000);
    chk_out("R5 vdd only", 1, 0, 0, 2);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_wr(8'h24, 32'd0);
    bus_wr(8'h20, 32'hFFFF_FFFF);
    bus_wr(8'h1A, 32'hFFFF_FFFF);
    bus_rd(8'h20, d); check("R8 read zero", d, 0);
    bus_rd(8'h18, d); check("R8 lvlA intact", d, {half(1,1,2,0), half(2,1,2,1)});
    bus_rd(8'h1C, d); check("R8 lvlB intact", d, {half(4,1,0,2), half(0,1,1,3)});
    bus_rd(8'h30, d); check("R8 load intact", d, 32'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    t_reset();
    t_program();
    t_levels();
    t_lock();
    t_partial();
    t_unmapped();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule